// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This block carries out one step of a 32-bit non-restoring division, the job a CPU does when it runs a divide-step instruction. One step shifts the partial remainder left by one place, bringing the incoming T flag in at the bottom. It then either adds or subtracts the divisor. After that it works out a new Q flag from the carry or borrow, and a new T flag that holds the next quotient bit. M is the divisor-sign flag. It is only read and is never changed. The step path is purely combinational, so it fits inside a one-cycle execute stage. Alongside it, a decoder recognises the 16-bit instruction word, gives the two register-select fields, and gives the program-counter advance.

A registered iterator sits next to the combinational path. A start strobe loads the partial remainder, the low dividend word, the divisor and the three flags. The iterator then runs 32 cycles of a rotate-through-T followed by a divide step. After the last step it performs one final rotate, which leaves the unsigned quotient in the low word. For an unsigned divide, start with the partial remainder at zero and Q, M and T all cleared.

Top module: `nrdiv_step_unit`

## Requirements
- R1: The intermediate Q of a step is bit 31 of `rn_in` taken before the shift. The shifted operand is `{rn_in[30:0], t_in}`.
- R2: The step subtracts `rm_in` from the shifted operand when `q_in` equals `m_in`, and adds it when they differ. The 32-bit result is returned on `step_rn`.
- R3: The carry/borrow flag is 1 in two cases: on a subtract when the unsigned result is greater than the shifted operand, and on an add when the unsigned result is less than the shifted operand.
- R4: `step_q` equals intermediate Q XOR carry/borrow flag XOR `m_in`.
- R5: `step_t` is 1 exactly when `step_q` equals `m_in`.
- R6: `insn_match` is 1 exactly when `insn[15:12]` is 4'b0011 and `insn[3:0]` is 4'b0100. `rn_sel` is always `insn[11:8]` and `rm_sel` is always `insn[7:4]`.
- R7: `pc_incr` is 2 while `insn_match` is 1, and 0 otherwise.
- R8: A `start` pulse seen while `busy` is 0 loads `rn_in`, `q_in` and `t_in` into `acc_rn`, `acc_q` and `acc_t`, and sets `busy` from the next cycle on.
- R9: Each busy cycle first rotates `{lo, T}` left, feeding the old `lo[31]` in as T, and then applies one R1–R5 step to the accumulated state. After 32 steps, `busy` falls and `done` is 1 for exactly one cycle.
- R10: With `rn_in`=0 and Q=M=T=0 at start, `quo` equals the unsigned quotient `dvd_lo / rm_in` (for a nonzero divisor) when `done` is 1.
- R11: After reset, `busy`, `done`, `acc_rn`, `acc_q`, `acc_t` and `quo` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn | input | 16 | Instruction word to decode |
| rn_in | input | 32 | Partial remainder / dividend high word |
| rm_in | input | 32 | Divisor |
| dvd_lo | input | 32 | Low dividend word for the iterator |
| q_in | input | 1 | Incoming Q flag |
| m_in | input | 1 | Divisor-sign flag M |
| t_in | input | 1 | Incoming T flag |
| start | input | 1 | Start strobe for the iterator |
| step_rn | output | 32 | Combinational step result |
| step_q | output | 1 | Combinational new Q |
| step_t | output | 1 | Combinational new T |
| insn_match | output | 1 | Instruction word is a divide step |
| rn_sel | output | 4 | Remainder register select field |
| rm_sel | output | 4 | Divisor register select field |
| pc_incr | output | 3 | Program-counter advance |
| busy | output | 1 | Iterator running |
| done | output | 1 | One-cycle completion pulse |
| acc_rn | output | 32 | Iterator partial remainder |
| acc_q | output | 1 | Iterator Q flag |
| acc_t | output | 1 | Iterator T flag |
| quo | output | 32 | Iterator low word / quotient |

## Verification
Some properties are checked on every cycle: the link between the new T and the new Q against M, the program-counter advance tied to a decode hit, that a start from idle raises busy, and that done is a single-cycle pulse that never overlaps busy. Other behaviours can only be shown by the bench scenarios. These include the exact carry/borrow results for each combination of Q, M and T, the step-by-step path of the remainder through a whole division, and the final quotient for corner operands: divisor 1, an all-ones dividend, and a dividend smaller than the divisor.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
   localparam logic [3:0] OPC_TOP = 4'b0011;
   localparam logic [3:0] OPC_BOT = 4'b0100;
   localparam int         SEL_W   = 4;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic q;
      logic t;
   } div_flags_t;
endpackage

// File: rtl/nrdiv_decode.sv
module nrdiv_decode
   import nrdiv_pkg::*;
#(
   parameter int IW      = 16,
   parameter int PC_W    = 3,
   parameter int PC_STEP = 2
) (
   input  logic [IW-1:0]    insn,
   output logic             hit,
   output logic [SEL_W-1:0] sel_n,
   output logic [SEL_W-1:0] sel_m,
   output logic [PC_W-1:0]  pc_adv
);
   localparam int TOP_LSB = IW - 4;
   localparam int N_LSB   = 8;
   localparam int M_LSB   = 4;

   if (IW != 16) begin : g_bad_iw
      $error("nrdiv_decode: instruction width must be 16");
   end
   if (PC_STEP >= (1 << PC_W)) begin : g_bad_pc
      $error("nrdiv_decode: PC_STEP does not fit PC_W");
   end

   always_comb begin
      hit    = (insn[IW-1:TOP_LSB] == OPC_TOP) && (insn[3:0] == OPC_BOT);
      sel_n  = insn[N_LSB +: SEL_W];
      sel_m  = insn[M_LSB +: SEL_W];
      pc_adv = hit ? PC_W'(PC_STEP) : '0;
   end
endmodule

// File: rtl/nrdiv_core.sv
module nrdiv_core
   import nrdiv_pkg::*;
#(
   parameter int W              = 32,
   parameter bit CARRY_FROM_EXT = 1'b1
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] dvs_i,
   input  logic         q_i,
   input  logic         m_i,
   input  logic         t_i,
   output logic [W-1:0] rem_o,
   output div_flags_t   flg_o
);
   logic         q_mid;
   logic [W-1:0] shifted;
   logic         do_sub;
   logic [W-1:0] res;
   logic         cb;

   always_comb begin
      q_mid   = rem_i[W-1];
      shifted = {rem_i[W-2:0], t_i};
      do_sub  = (q_i == m_i);
   end

   if (CARRY_FROM_EXT) begin : g_ext
      logic [W:0] wide;
      always_comb begin
         if (do_sub) wide = {1'b0, shifted} - {1'b0, dvs_i};
         else        wide = {1'b0, shifted} + {1'b0, dvs_i};
         res = wide[W-1:0];
         cb  = wide[W];
      end
   end else begin : g_cmp
      always_comb begin
         if (do_sub) begin
            res = shifted - dvs_i;
            cb  = (res > shifted);
         end else begin
            res = shifted + dvs_i;
            cb  = (res < shifted);
         end
      end
   end

   always_comb begin
      rem_o   = res;
      flg_o.q = q_mid ^ cb ^ m_i;
      flg_o.t = ~(q_mid ^ cb);
   end
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq
   import nrdiv_pkg::*;
#(
   parameter int W              = 32,
   parameter int ITER           = 32,
   parameter bit CARRY_FROM_EXT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] rem_ld,
   input  logic [W-1:0] lo_ld,
   input  logic [W-1:0] dvs_ld,
   input  logic         q_ld,
   input  logic         m_ld,
   input  logic         t_ld,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rem_q,
   output logic [W-1:0] lo_q,
   output div_flags_t   flg_q
);
   localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
   localparam logic [CW-1:0] LAST = CW'(ITER - 1);

   if (ITER < 2 || ITER > W) begin : g_bad_iter
      $error("nrdiv_seq: ITER must lie in 2..W");
   end

   seq_state_e   st;
   logic [CW-1:0] cnt;
   logic [W-1:0] dvs_r;
   logic         m_r;

   logic         t_feed;
   logic [W-1:0] lo_rot;
   logic [W-1:0] rem_nx;
   div_flags_t   flg_nx;

   always_comb begin
      t_feed = lo_q[W-1];
      lo_rot = {lo_q[W-2:0], flg_q.t};
   end

   nrdiv_core #(.W(W), .CARRY_FROM_EXT(CARRY_FROM_EXT)) u_step (
      .rem_i (rem_q),
      .dvs_i (dvs_r),
      .q_i   (flg_q.q),
      .m_i   (m_r),
      .t_i   (t_feed),
      .rem_o (rem_nx),
      .flg_o (flg_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SEQ_IDLE;
         cnt   <= '0;
         dvs_r <= '0;
         m_r   <= 1'b0;
         rem_q <= '0;
         lo_q  <= '0;
         flg_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            SEQ_IDLE: begin
               if (start) begin
                  st      <= SEQ_RUN;
                  cnt     <= '0;
                  dvs_r   <= dvs_ld;
                  m_r     <= m_ld;
                  rem_q   <= rem_ld;
                  lo_q    <= lo_ld;
                  flg_q.q <= q_ld;
                  flg_q.t <= t_ld;
               end
            end
            SEQ_RUN: begin
               rem_q <= rem_nx;
               flg_q <= flg_nx;
               cnt   <= cnt + 1'b1;
               if (cnt == LAST) begin
                  st   <= SEQ_IDLE;
                  done <= 1'b1;
                  lo_q <= {lo_rot[W-2:0], flg_nx.t};
               end else begin
                  lo_q <= lo_rot;
               end
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = (st == SEQ_RUN);
endmodule

// File: rtl/nrdiv_step_unit.sv
module nrdiv_step_unit
   import nrdiv_pkg::*;
#(
   parameter int W              = 32,
   parameter int IW             = 16,
   parameter int PC_W           = 3,
   parameter int PC_STEP        = 2,
   parameter bit CARRY_FROM_EXT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] insn,
   input  logic [W-1:0]  rn_in,
   input  logic [W-1:0]  rm_in,
   input  logic [W-1:0]  dvd_lo,
   input  logic          q_in,
   input  logic          m_in,
   input  logic          t_in,
   input  logic          start,
   output logic [W-1:0]  step_rn,
   output logic          step_q,
   output logic          step_t,
   output logic          insn_match,
   output logic [3:0]    rn_sel,
   output logic [3:0]    rm_sel,
   output logic [PC_W-1:0] pc_incr,
   output logic          busy,
   output logic          done,
   output logic [W-1:0]  acc_rn,
   output logic          acc_q,
   output logic          acc_t,
   output logic [W-1:0]  quo
);
   localparam int ITER = W;

   if (W < 2) begin : g_bad_w
      $error("nrdiv_step_unit: W must be at least 2");
   end

   div_flags_t comb_flg;
   div_flags_t seq_flg;

   nrdiv_decode #(.IW(IW), .PC_W(PC_W), .PC_STEP(PC_STEP)) u_dec (
      .insn   (insn),
      .hit    (insn_match),
      .sel_n  (rn_sel),
      .sel_m  (rm_sel),
      .pc_adv (pc_incr)
   );

   nrdiv_core #(.W(W), .CARRY_FROM_EXT(CARRY_FROM_EXT)) u_core (
      .rem_i (rn_in),
      .dvs_i (rm_in),
      .q_i   (q_in),
      .m_i   (m_in),
      .t_i   (t_in),
      .rem_o (step_rn),
      .flg_o (comb_flg)
   );

   nrdiv_seq #(.W(W), .ITER(ITER), .CARRY_FROM_EXT(CARRY_FROM_EXT)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .rem_ld (rn_in),
      .lo_ld  (dvd_lo),
      .dvs_ld (rm_in),
      .q_ld   (q_in),
      .m_ld   (m_in),
      .t_ld   (t_in),
      .busy   (busy),
      .done   (done),
      .rem_q  (acc_rn),
      .lo_q   (quo),
      .flg_q  (seq_flg)
   );

   always_comb begin
      step_q = comb_flg.q;
      step_t = comb_flg.t;
      acc_q  = seq_flg.q;
      acc_t  = seq_flg.t;
   end
endmodule

// File: rtl/nrdiv_step_chk.sv
module nrdiv_step_chk #(
   parameter int PC_W    = 3,
   parameter int PC_STEP = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            m_in,
   input logic            start,
   input logic            step_q,
   input logic            step_t,
   input logic            insn_match,
   input logic [PC_W-1:0] pc_incr,
   input logic            busy,
   input logic            done
);
   assert_t_tracks_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_t == (step_q == m_in));

   assert_pc_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      insn_match |-> (pc_incr == PC_W'(PC_STEP)));

   assert_pc_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_match |-> (pc_incr == '0));

   assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind nrdiv_step_unit nrdiv_step_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m_in       (m_in),
   .start      (start),
   .step_q     (step_q),
   .step_t     (step_t),
   .insn_match (insn_match),
   .pc_incr    (pc_incr),
   .busy       (busy),
   .done       (done)
);

// File: tb/tb_nrdiv_step_unit.sv
module tb_nrdiv_step_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] insn = '0;
   logic [31:0] rn_in = '0, rm_in = '0, dvd_lo = '0;
   logic        q_in = 1'b0, m_in = 1'b0, t_in = 1'b0, start = 1'b0;
   logic [31:0] step_rn, acc_rn, quo;
   logic        step_q, step_t, insn_match, busy, done, acc_q, acc_t;
   logic [3:0]  rn_sel, rm_sel;
   logic [2:0]  pc_incr;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   nrdiv_step_unit dut (
      .clk(clk), .rst_n(rst_n), .insn(insn), .rn_in(rn_in), .rm_in(rm_in),
      .dvd_lo(dvd_lo), .q_in(q_in), .m_in(m_in), .t_in(t_in), .start(start),
      .step_rn(step_rn), .step_q(step_q), .step_t(step_t),
      .insn_match(insn_match), .rn_sel(rn_sel), .rm_sel(rm_sel),
      .pc_incr(pc_incr), .busy(busy), .done(done), .acc_rn(acc_rn),
      .acc_q(acc_q), .acc_t(acc_t), .quo(quo)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural model of one step: returns {rem, q, t}
   function automatic logic [33:0] ref_step(input logic [31:0] rn, input logic [31:0] rm,
                                            input logic q, input logic m, input logic t);
      logic        qi;
      logic [31:0] sh;
      logic [31:0] r;
      logic        c;
      logic        qn;
      qi = rn[31];
      sh = {rn[30:0], t};
      if (q == m) begin
         r = sh - rm;
         c = (r > sh);
      end else begin
         r = sh + rm;
         c = (r < sh);
      end
      if (!m) qn = qi ? !c : c;
      else    qn = qi ? c : !c;
      return {r, qn, (qn == m)};
   endfunction

   task automatic comb_case(input logic [31:0] rn, input logic [31:0] rm,
                            input logic q, input logic m, input logic t);
      logic [33:0] e;
      @(negedge clk);
      rn_in = rn; rm_in = rm; q_in = q; m_in = m; t_in = t;
      #1;
      e = ref_step(rn, rm, q, m, t);
      check("R1/R2 step_rn", step_rn, e[33:2]);
      check("R3/R4 step_q", step_q, e[1]);
      check("R5 step_t", step_t, e[0]);
   endtask

   task automatic run_div(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] rem, lo;
      logic        q, t, tf;
      logic [33:0] e;
      @(negedge clk);
      rn_in = '0; dvd_lo = a; rm_in = b; q_in = 0; m_in = 0; t_in = 0; start = 1;
      rem = '0; lo = a; q = 0; t = 0;
      @(negedge clk);
      start = 0;
      rn_in = 32'hDEAD_BEEF; rm_in = 32'h1234_5678; dvd_lo = '0; m_in = 1;
      check("R8 busy after start", busy, 1);
      check("R8 loaded acc_rn", acc_rn, rem);
      check("R8 loaded flags", {acc_q, acc_t}, {q, t});
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         tf = lo[31];
         lo = {lo[30:0], t};
         e  = ref_step(rem, b, q, 1'b0, tf);
         rem = e[33:2]; q = e[1]; t = e[0];
         if (i == 31) lo = {lo[30:0], t};
         check("R9 acc_rn per step", acc_rn, rem);
         check("R9 flags per step", {acc_q, acc_t}, {q, t});
         check("R9 busy/done", {busy, done}, (i == 31) ? 2'b01 : 2'b10);
      end
      check("R10 quotient vs model", quo, lo);
      check("R10 quotient vs a/b", quo, a / b);
      @(negedge clk);
      check("R9 done one cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset busy/done", {busy, done}, 0);
      check("R11 reset acc", {acc_rn, acc_q, acc_t}, 0);
      check("R11 reset quo", quo, 0);
      rst_n = 1;

      // R6 R7 decode
      for (int k = 0; k < 40; k++) begin
         logic [15:0] w;
         w = (k < 20) ? {4'b0011, 8'($urandom), 4'b0100} : 16'($urandom);
         if (k == 20) w = 16'h3105;
         if (k == 21) w = 16'h2104;
         @(negedge clk);
         insn = w;
         #1;
         check("R6 insn_match", insn_match, (w[15:12] == 4'b0011) && (w[3:0] == 4'b0100));
         check("R6 select fields", {rn_sel, rm_sel}, w[11:4]);
         check("R7 pc_incr", pc_incr, ((w[15:12] == 4'b0011) && (w[3:0] == 4'b0100)) ? 3'd2 : 3'd0);
      end

      // R1..R5 combinational step, all flag combinations
      for (int f = 0; f < 8; f++) begin
         comb_case(32'h8000_0000, 32'h0000_0001, f[2], f[1], f[0]);
         comb_case(32'h7FFF_FFFF, 32'hFFFF_FFFF, f[2], f[1], f[0]);
         comb_case(32'h0000_0000, 32'h0000_0000, f[2], f[1], f[0]);
         comb_case(32'hFFFF_FFFF, 32'h0000_0001, f[2], f[1], f[0]);
         for (int r = 0; r < 6; r++)
            comb_case($urandom, $urandom, f[2], f[1], f[0]);
      end

      // R8 R9 R10 iterated divides
      run_div(32'd100, 32'd7);
      run_div(32'hFFFF_FFFF, 32'd1);
      run_div(32'hFFFF_FFFF, 32'd3);
      run_div(32'd5, 32'd9);
      run_div(32'h8000_0000, 32'hFFFF_FFFF);
      run_div(32'd0, 32'd13);
      for (int r = 0; r < 6; r++) begin
         logic [31:0] b;
         b = $urandom;
         if (r % 2 == 1) b = b >> (r * 4);
         if (b == 0) b = 1;
         run_div($urandom, b);
      end
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule